// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns characters into asynchronous serial frames on a single output line. Software-side logic, or any other producer, drops a character of up to nine bits into a one-entry holding register. Whenever the transmitter is enabled and its shift stage is free, the character moves into the shift stage. The holding register is then free again, so the next character can be queued while the current one is still on the line.

The frame shape is set by three inputs, which are captured when a character enters the shift stage:

- character length: five to nine bits;
- parity: none, even or odd;
- stop bits: one or two.

Bit timing comes from an external one-cycle tick, one tick per bit period. The block itself holds no divider.

Two flags report progress:

- The empty flag tells the producer when it may write.
- The complete flag reports that the line has gone quiet with nothing left queued.

Top module: `serial_tx`

## Requirements
- R1: After reset `txd_o` is 1 (mark), `buf_empty_o` is 1 and `tx_done_o` is 0; the line is 1 whenever no frame is being sent.
- R2: A frame is a 0 start bit followed by the data bits, least significant first, then the optional parity bit, then the stop bits.
- R3: `char_size_i` selects the data bit count: codes 0,1,2,3,4 give 5,6,7,8,9 bits, and codes 5,6,7 give 9 bits.
- R4: `parity_mode_i` 2'b00 or 2'b01 sends no parity bit; 2'b10 sends a bit making the count of ones in data plus parity even; 2'b11 makes that count odd. The parity bit directly follows the last data bit.
- R5: `stop_two_i` = 0 sends one stop bit of value 1; `stop_two_i` = 1 sends two.
- R6: A write (`wr_i` high) is accepted only while `buf_empty_o` is 1, and `buf_empty_o` is 0 in the cycle after an accepted write. A write while `buf_empty_o` is 0 is ignored and its data is never sent.
- R7: With `tx_en_i` high and the shift stage free, a held character moves into the shift stage on the next clock, and `buf_empty_o` is 1 from that edge.
- R8: If a character is held when the last stop bit of a frame ends and `tx_en_i` is high, its start bit follows with no idle bit in between.
- R9: `tx_done_o` becomes 1 when the last stop bit ends while the holding register is empty, and returns to 0 on the next accepted write.
- R10: Dropping `tx_en_i` lets the frame already loaded finish; a character written while `tx_en_i` is low is held, and nothing is sent until `tx_en_i` is high again.
- R11: Each bit lasts exactly one tick period: `txd_o` changes only in the clock cycle following a cycle with `bit_tick_i` high, and a start bit begins on the first tick after a load from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit period |
| tx_en_i | input | 1 | Allows characters to move from the holding register to the shift stage |
| char_size_i | input | 3 | Data bit count code |
| parity_mode_i | input | 2 | Parity selection |
| stop_two_i | input | 1 | Two stop bits when high |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 9 | Character to send; bits above the selected length are unused |
| txd_o | output | 1 | Serial line |
| buf_empty_o | output | 1 | Holding register may be written |
| tx_done_o | output | 1 | Last frame finished and nothing is queued |

## Verification
The properties assume that `bit_tick_i` is a single-cycle pulse. They also assume that the frame configuration holds steady from a write until that character has been loaded. The bench produces the tick from a free-running counter, one cycle high in four. It changes the configuration only while the holding register is empty and the line is idle, or keeps it fixed across back-to-back characters. Writes are driven on falling clock edges, so the strobe is always stable at the sampling edge.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  localparam int MAX_BITS = 9;
  localparam int MIN_BITS = 5;
  localparam int NB_W     = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    PAR_OFF   = 2'b00,
    PAR_OFF_B = 2'b01,
    PAR_EVEN  = 2'b10,
    PAR_ODD   = 2'b11
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARMED, ST_START, ST_DATA, ST_PARITY, ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [NB_W-1:0] nbits;
    logic            par_en;
    logic            par_odd;
    logic            two_stop;
  } frame_cfg_t;

  function automatic frame_cfg_t decode_cfg(logic [2:0] size, par_mode_e par, logic two);
    frame_cfg_t c;
    if (int'(size) <= MAX_BITS - MIN_BITS) c.nbits = NB_W'(MIN_BITS + int'(size));
    else                                   c.nbits = NB_W'(MAX_BITS);
    c.par_en   = (par == PAR_EVEN) || (par == PAR_ODD);
    c.par_odd  = (par == PAR_ODD);
    c.two_stop = two;
    return c;
  endfunction
endpackage

// File: rtl/serial_tx_hold.sv
module serial_tx_hold import serial_tx_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [MAX_BITS-1:0] wr_data_i,
  input  logic                take_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                empty_o,
  output logic                accept_o
);
  logic [MAX_BITS-1:0] data_q;
  logic                empty_q;

  assign accept_o = wr_i && empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (accept_o) begin
      data_q  <= wr_data_i;
      empty_q <= 1'b0;
    end else if (take_i) begin
      empty_q <= 1'b1;
    end
  end

  assign data_o  = data_q;
  assign empty_o = empty_q;
endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter import serial_tx_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] load_data_i,
  input  frame_cfg_t          cfg_i,
  output logic                txd_o,
  output logic                ready_o,
  output logic                frame_end_o
);
  tx_state_e           state_q;
  frame_cfg_t          cfg_q;
  logic [MAX_BITS-1:0] shreg_q;
  logic [MAX_BITS-1:0] mask;
  logic [NB_W-1:0]     bit_cnt_q;
  logic                stop_cnt_q;
  logic                par_q;
  logic                last_stop;

  // valid-bit mask for the incoming character length
  for (genvar g = 0; g < MAX_BITS; g++) begin : g_mask
    assign mask[g] = (NB_W'(g) < cfg_i.nbits);
  end

  assign last_stop   = !cfg_q.two_stop || stop_cnt_q;
  assign frame_end_o = tick_i && (state_q == ST_STOP) && last_stop;
  assign ready_o     = (state_q == ST_IDLE) || frame_end_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cfg_q      <= '0;
      shreg_q    <= '0;
      bit_cnt_q  <= '0;
      stop_cnt_q <= 1'b0;
      par_q      <= 1'b0;
    end else if (load_i) begin
      // from idle wait for the next tick; after a stop bit start at once
      state_q    <= (state_q == ST_IDLE) ? ST_ARMED : ST_START;
      cfg_q      <= cfg_i;
      shreg_q    <= load_data_i;
      bit_cnt_q  <= '0;
      stop_cnt_q <= 1'b0;
      par_q      <= (^(load_data_i & mask)) ^ cfg_i.par_odd;
    end else if (tick_i) begin
      unique case (state_q)
        ST_ARMED:  state_q <= ST_START;
        ST_START:  state_q <= ST_DATA;
        ST_DATA: begin
          shreg_q   <= shreg_q >> 1;
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == cfg_q.nbits - 1'b1)
            state_q <= cfg_q.par_en ? ST_PARITY : ST_STOP;
        end
        ST_PARITY: state_q <= ST_STOP;
        ST_STOP: begin
          if (last_stop) state_q    <= ST_IDLE;
          else           stop_cnt_q <= 1'b1;
        end
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START:  txd_o = 1'b0;
      ST_DATA:   txd_o = shreg_q[0];
      ST_PARITY: txd_o = par_q;
      default:   txd_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/serial_tx.sv
module serial_tx import serial_tx_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_tick_i,
  input  logic                tx_en_i,
  input  logic [2:0]          char_size_i,
  input  logic [1:0]          parity_mode_i,
  input  logic                stop_two_i,
  input  logic                wr_i,
  input  logic [MAX_BITS-1:0] wr_data_i,
  output logic                txd_o,
  output logic                buf_empty_o,
  output logic                tx_done_o
);
  frame_cfg_t          cfg;
  logic [MAX_BITS-1:0] held_data;
  logic                held_empty;
  logic                wr_accept;
  logic                sh_ready;
  logic                frame_end;
  logic                load;
  logic                done_q;

  assign cfg  = decode_cfg(char_size_i, par_mode_e'(parity_mode_i), stop_two_i);
  assign load = tx_en_i && !held_empty && sh_ready;

  serial_tx_hold i_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .take_i    (load),
    .data_o    (held_data),
    .empty_o   (held_empty),
    .accept_o  (wr_accept)
  );

  serial_tx_shifter i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (bit_tick_i),
    .load_i      (load),
    .load_data_i (held_data),
    .cfg_i       (cfg),
    .txd_o       (txd_o),
    .ready_o     (sh_ready),
    .frame_end_o (frame_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       done_q <= 1'b0;
    else if (wr_accept)                done_q <= 1'b0;
    else if (frame_end && held_empty)  done_q <= 1'b1;
  end

  assign buf_empty_o = held_empty;
  assign tx_done_o   = done_q;
endmodule

// File: rtl/serial_tx_checker.sv
module serial_tx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_tick_i,
  input logic tx_en_i,
  input logic wr_i,
  input logic txd_o,
  input logic buf_empty_o,
  input logic tx_done_o
);
  p_idle_when_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> txd_o);

  p_write_fills_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && buf_empty_o |=> !buf_empty_o);

  p_done_needs_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> buf_empty_o);

  p_write_clears_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && buf_empty_o |=> !tx_done_o);

  p_hold_while_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i && !buf_empty_o |=> !buf_empty_o);

  p_txd_on_tick_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> $past(bit_tick_i));
endmodule

bind serial_tx serial_tx_checker i_checker (.*);

// File: tb/test_serial_tx.sv
module test_serial_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       en = 1'b0;
  logic [2:0] size = 3'd3;
  logic [1:0] pmode = 2'b00;
  logic       two = 1'b0;
  logic       wr = 1'b0;
  logic [8:0] wdata = '0;
  logic       txd, empty, done;
  int         checks = 0;
  int         fails = 0;
  int         tick_cnt = 0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % 4;
    tick = (tick_cnt == 0);
  end

  serial_tx i_serial_tx (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .tx_en_i(en),
    .char_size_i(size), .parity_mode_i(pmode), .stop_two_i(two),
    .wr_i(wr), .wr_data_i(wdata),
    .txd_o(txd), .buf_empty_o(empty), .tx_done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic next_bit(output logic b);
    do @(posedge clk); while (!tick);
    @(negedge clk);
    b = txd;
  endtask

  task automatic write(input logic [8:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic int nbits_of(input logic [2:0] code);
    return (code <= 3'd4) ? 5 + int'(code) : 9;
  endfunction

  task automatic expect_frame(input logic [8:0] d, input int max_idle, input string req);
    int nb, len, idle;
    logic b, par;
    logic [15:0] exp_v, act_v;
    nb = nbits_of(size);
    exp_v = '1; act_v = '1;
    exp_v[0] = 1'b0;
    par = pmode[0];
    for (int i = 0; i < nb; i++) begin
      exp_v[1+i] = d[i];
      par ^= d[i];
    end
    len = 1 + nb;
    if (pmode[1]) begin exp_v[len] = par; len++; end
    len += two ? 2 : 1;
    idle = 0;
    next_bit(b);
    while (b && idle < 40) begin idle++; next_bit(b); end
    chk(!b && idle <= max_idle, {req, " start bit"}, idle, max_idle);
    act_v[0] = b;
    for (int i = 1; i < len; i++) begin
      next_bit(b);
      act_v[i] = b;
    end
    chk(act_v == exp_v, {req, " frame bits"}, int'(act_v), int'(exp_v));
  endtask

  task automatic after_frame(input string req);
    logic b;
    next_bit(b);
    chk(done == 1'b1, {req, " R9 done set"}, done, 1);
    chk(b == 1'b1, {req, " R1 line idle"}, b, 1);
  endtask

  task automatic t_reset();
    chk(txd == 1'b1, "R1 reset txd", txd, 1);
    chk(empty == 1'b1, "R1 reset empty", empty, 1);
    chk(done == 1'b0, "R1 reset done", done, 0);
  endtask

  task automatic t_frame(input logic [8:0] d, input logic [2:0] code,
                         input logic [1:0] pm, input logic st2, input string req);
    @(negedge clk);
    size = code; pmode = pm; two = st2; en = 1'b1;
    write(d);
    chk(empty == 1'b0, {req, " R6 write fills"}, empty, 0);
    chk(done == 1'b0, {req, " R9 write clears done"}, done, 0);
    @(negedge clk);
    chk(empty == 1'b1, {req, " R7 load empties"}, empty, 1);
    expect_frame(d, 1, {req, " R11"});
    after_frame(req);
  endtask

  task automatic t_full_ignored();
    @(negedge clk);
    en = 1'b0; size = 3'd3; pmode = 2'b00; two = 1'b0;
    write(9'h05A);
    write(9'h03C);
    chk(empty == 1'b0, "R6 full stays full", empty, 0);
    @(negedge clk);
    en = 1'b1;
    expect_frame(9'h05A, 2, "R6 first char kept");
    after_frame("R6 second write dropped");
    chk(empty == 1'b1, "R6 nothing left", empty, 1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    en = 1'b1; size = 3'd3; pmode = 2'b10; two = 1'b0;
    write(9'h0C3);
    while (!empty) @(negedge clk);
    write(9'h017);
    expect_frame(9'h0C3, 1, "R8 first");
    expect_frame(9'h017, 0, "R8 no gap");
    after_frame("R8");
  endtask

  task automatic t_disable();
    logic b;
    bit all_mark;
    @(negedge clk);
    en = 1'b1; size = 3'd2; pmode = 2'b11; two = 1'b1;
    write(9'h055);
    @(negedge clk);
    en = 1'b0;
    expect_frame(9'h055, 1, "R10 loaded frame finishes");
    after_frame("R10");
    write(9'h02B);
    all_mark = 1'b1;
    for (int i = 0; i < 15; i++) begin
      next_bit(b);
      if (!b) all_mark = 1'b0;
    end
    chk(all_mark, "R10 line quiet while disabled", all_mark, 1);
    chk(empty == 1'b0, "R10 char held", empty, 0);
    chk(done == 1'b0, "R10 done low while held", done, 0);
    @(negedge clk);
    en = 1'b1;
    expect_frame(9'h02B, 2, "R10 sent after enable");
    after_frame("R10 resumed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_frame(9'h0A5, 3'd3, 2'b00, 1'b0, "R2 8N1");
    t_frame(9'h013, 3'd0, 2'b00, 1'b0, "R3 5 bits");
    t_frame(9'h1A5, 3'd4, 2'b10, 1'b0, "R3 R4 9 bits even");
    t_frame(9'h06B, 3'd2, 2'b11, 1'b0, "R4 7 bits odd");
    t_frame(9'h0F0, 3'd3, 2'b10, 1'b0, "R4 even zero-sum");
    t_frame(9'h03F, 3'd1, 2'b01, 1'b0, "R4 alt code none");
    t_frame(9'h155, 3'd7, 2'b00, 1'b0, "R3 code 7 is 9 bits");
    t_frame(9'h09C, 3'd3, 2'b00, 1'b1, "R5 two stops");
    t_frame(9'h1FF, 3'd4, 2'b11, 1'b1, "R5 9O2");
    t_full_ignored();
    t_back_to_back();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog R1..: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule